// File: doc/BRIEF.md
# Card Management Register Bank

This block is the control register file of a removable memory card, sitting in attribute space at even byte offsets from 4000h upward. The host reaches it through a byte-wide synchronous port: a register-select input marks an attribute-space access, and a write strobe or a read strobe acts on the rising clock edge. The block keeps a soft-reset control, a global power-down control, a socket/copy identity, a write-protection control and a per-device-pair sleep selection.

From these registers it drives a soft-reset output, one deep power-down enable per device pair, and three write-permission signals for the rest of the card: one for the information-table region, one for the remaining common memory and one for the other attribute-space locations. A read-only status byte is built on the fly from the register contents, the live write-protect switch and the ready and mask lines of the flash devices. Writes to this register region are never gated by the switch.

Top module: `card_mgmt_regs`

## Requirements
- R1: A synchronous reset clears every writable register to 0 and drives rdata, soft_reset, pair_pwrdn, cis_wr_ok, cm_wr_ok and attr_wr_ok to 0.
- R2: Registers decode only with sel high and an even address; a write with addr[0]=1 or sel low changes no register, and a read of an odd, unmapped or unselected address returns 00h.
- R3: Offset 4000h holds the soft-reset control in bit 7 (1 holds reset, 0 ends it); it drives soft_reset directly from the clock edge of the write, bits 6:0 read as 0.
- R4: Offset 4002h holds the power-down bit in bit 2 (other bits read 0); one clock after the registers hold a value, pair_pwrdn[i] equals that power-down bit AND sleep bit i.
- R5: Offset 4006h is a read/write byte whose bits 3:0 are the socket number and bits 6:4 the copy number; bit 7 reads as 0.
- R6: A read of offset 4100h returns bit7 = OR of dev_mask, bit6 = OR of the sleep bits, bit5 = soft-reset bit, bit4 = common-memory protect bit, bit3 = power-down bit, bit2 = table protect bit, bit1 = wp_switch, bit0 = 1 only when every device is ready or masked; register and live inputs are taken at the read edge.
- R7: Offset 4100h is read-only; writing it changes no register.
- R8: Offset 4104h stores bit 0 (table protect), bit 1 (common-memory protect) and bit 2 (block-lock enable) and reads them back; bit 2 has no effect on any output.
- R9: One clock after the inputs and registers hold a value, attr_wr_ok = NOT wp_switch, cis_wr_ok = NOT wp_switch AND NOT bit 0 of 4104h, cm_wr_ok = NOT wp_switch AND NOT bit 1 of 4104h.
- R10: Writes to this register region take effect whatever the state of wp_switch.
- R11: rdata is registered: it takes the addressed value at a clock edge with rd_en high (a read in the same cycle as a write returns the old value) and holds otherwise.
- R12: Offset 4118h holds sleep bits for pairs 0..NPAIR-1 in bits NPAIR-1:0, upper bits read 0; offset 411Ah reads 00h and writing it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Attribute-space register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address in attribute space |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| wp_switch | input | 1 | Live write-protect switch, 1 = protected |
| dev_ready | input | 2*NPAIR | Per-device ready lines, 1 = ready |
| dev_mask | input | 2*NPAIR | Per-device ready/busy mask, 1 = masked |
| soft_reset | output | 1 | Soft-reset control |
| pair_pwrdn | output | NPAIR | Deep power-down enable per device pair |
| cis_wr_ok | output | 1 | Information-table region writes allowed |
| cm_wr_ok | output | 1 | Remaining common-memory writes allowed |
| attr_wr_ok | output | 1 | Attribute writes outside this region allowed |

## Verification
The checker watches on every cycle the one-cycle relation of the gating outputs to the switch and protect bits, the combination of power-down and sleep bits into pair_pwrdn, the soft-reset write path, the holding of rdata between reads, and that odd-address and status-register writes leave the stored state alone, including under an active switch. The exact bit assembly of the status byte from mixed live and stored sources, the zero readback of reserved bits and unmapped offsets, the read-before-write ordering and the inertness of the block-lock bit are shown only by the bench, which compares every read and output against a model over random and directed traffic.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
  localparam logic [15:0] OFF_COR    = 16'h4000;
  localparam logic [15:0] OFF_CCR    = 16'h4002;
  localparam logic [15:0] OFF_SCK    = 16'h4006;
  localparam logic [15:0] OFF_CSR    = 16'h4100;
  localparam logic [15:0] OFF_WPR    = 16'h4104;
  localparam logic [15:0] OFF_SLP_LO = 16'h4118;
  localparam logic [15:0] OFF_SLP_HI = 16'h411A;

  localparam int COR_SR_BIT = 7;
  localparam int CCR_PD_BIT = 2;
  localparam int WP_CIS_BIT = 0;
  localparam int WP_CM_BIT  = 1;
  localparam int WP_BLK_BIT = 2;
  localparam int SCK_W      = 7;
  localparam int WPR_W      = 3;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_COR, SEL_CCR, SEL_SCK, SEL_CSR, SEL_WPR, SEL_SLP
  } reg_sel_e;
endpackage

// File: rtl/cmr_decode.sv
module cmr_decode
  import cmr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          rsel
);
  always_comb begin
    rsel = SEL_NONE;
    if (sel && !addr[0]) begin
      if      (addr == OFF_COR[ADDR_W-1:0])    rsel = SEL_COR;
      else if (addr == OFF_CCR[ADDR_W-1:0])    rsel = SEL_CCR;
      else if (addr == OFF_SCK[ADDR_W-1:0])    rsel = SEL_SCK;
      else if (addr == OFF_CSR[ADDR_W-1:0])    rsel = SEL_CSR;
      else if (addr == OFF_WPR[ADDR_W-1:0])    rsel = SEL_WPR;
      else if (addr == OFF_SLP_LO[ADDR_W-1:0]) rsel = SEL_SLP;
    end
  end
endmodule

// File: rtl/cmr_regfile.sv
module cmr_regfile
  import cmr_pkg::*;
#(
  parameter int NPAIR = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         rsel,
  input  logic [7:0]       wdata,
  output logic             cor_sr,
  output logic             ccr_pd,
  output logic [SCK_W-1:0] sock_q,
  output logic [WPR_W-1:0] wpr_q,
  output logic [NPAIR-1:0] sleep_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cor_sr <= 1'b0;
      ccr_pd <= 1'b0;
      sock_q <= '0;
      wpr_q  <= '0;
    end else if (wr_en) begin
      case (rsel)
        SEL_COR: cor_sr <= wdata[COR_SR_BIT];
        SEL_CCR: ccr_pd <= wdata[CCR_PD_BIT];
        SEL_SCK: sock_q <= wdata[SCK_W-1:0];
        SEL_WPR: wpr_q  <= wdata[WPR_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NPAIR; i++) begin : g_sleep
    always_ff @(posedge clk) begin
      if (rst)                              sleep_q[i] <= 1'b0;
      else if (wr_en && rsel == SEL_SLP)    sleep_q[i] <= wdata[i];
    end
  end
endmodule

// File: rtl/cmr_status.sv
module cmr_status
  import cmr_pkg::*;
#(
  parameter int NPAIR = 6,
  localparam int NDEV = 2 * NPAIR
) (
  input  logic             cor_sr,
  input  logic             ccr_pd,
  input  logic [WPR_W-1:0] wpr_q,
  input  logic [NPAIR-1:0] sleep_q,
  input  logic             wp_switch,
  input  logic [NDEV-1:0]  dev_ready,
  input  logic [NDEV-1:0]  dev_mask,
  output logic [7:0]       status
);
  always_comb begin
    status[7] = |dev_mask;
    status[6] = |sleep_q;
    status[5] = cor_sr;
    status[4] = wpr_q[WP_CM_BIT];
    status[3] = ccr_pd;
    status[2] = wpr_q[WP_CIS_BIT];
    status[1] = wp_switch;
    status[0] = &(dev_ready | dev_mask);
  end
endmodule

// File: rtl/cmr_outputs.sv
module cmr_outputs
  import cmr_pkg::*;
#(
  parameter int NPAIR = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ccr_pd,
  input  logic [WPR_W-1:0] wpr_q,
  input  logic [NPAIR-1:0] sleep_q,
  input  logic             wp_switch,
  output logic [NPAIR-1:0] pair_pwrdn,
  output logic             cis_wr_ok,
  output logic             cm_wr_ok,
  output logic             attr_wr_ok
);
  for (genvar i = 0; i < NPAIR; i++) begin : g_pd
    always_ff @(posedge clk) begin
      if (rst) pair_pwrdn[i] <= 1'b0;
      else     pair_pwrdn[i] <= ccr_pd & sleep_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cis_wr_ok  <= 1'b0;
      cm_wr_ok   <= 1'b0;
      attr_wr_ok <= 1'b0;
    end else begin
      cis_wr_ok  <= !wp_switch && !wpr_q[WP_CIS_BIT];
      cm_wr_ok   <= !wp_switch && !wpr_q[WP_CM_BIT];
      attr_wr_ok <= !wp_switch;
    end
  end
endmodule

// File: rtl/card_mgmt_regs.sv
module card_mgmt_regs
  import cmr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int NPAIR  = 6,
  localparam int NDEV  = 2 * NPAIR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              wp_switch,
  input  logic [NDEV-1:0]   dev_ready,
  input  logic [NDEV-1:0]   dev_mask,
  output logic              soft_reset,
  output logic [NPAIR-1:0]  pair_pwrdn,
  output logic              cis_wr_ok,
  output logic              cm_wr_ok,
  output logic              attr_wr_ok
);
  reg_sel_e         rsel;
  logic             cor_sr;
  logic             ccr_pd;
  logic [SCK_W-1:0] sock_q;
  logic [WPR_W-1:0] wpr_q;
  logic [NPAIR-1:0] sleep_q;
  logic [7:0]       status;
  logic [7:0]       rd_mux;

  cmr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(sel), .addr(addr), .rsel(rsel)
  );

  cmr_regfile #(.NPAIR(NPAIR)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rsel(rsel), .wdata(wdata),
    .cor_sr(cor_sr), .ccr_pd(ccr_pd), .sock_q(sock_q), .wpr_q(wpr_q),
    .sleep_q(sleep_q)
  );

  cmr_status #(.NPAIR(NPAIR)) u_stat (
    .cor_sr(cor_sr), .ccr_pd(ccr_pd), .wpr_q(wpr_q), .sleep_q(sleep_q),
    .wp_switch(wp_switch), .dev_ready(dev_ready), .dev_mask(dev_mask),
    .status(status)
  );

  cmr_outputs #(.NPAIR(NPAIR)) u_out (
    .clk(clk), .rst(rst), .ccr_pd(ccr_pd), .wpr_q(wpr_q), .sleep_q(sleep_q),
    .wp_switch(wp_switch), .pair_pwrdn(pair_pwrdn), .cis_wr_ok(cis_wr_ok),
    .cm_wr_ok(cm_wr_ok), .attr_wr_ok(attr_wr_ok)
  );

  always_comb begin
    rd_mux = 8'h00;
    case (rsel)
      SEL_COR: rd_mux[COR_SR_BIT]  = cor_sr;
      SEL_CCR: rd_mux[CCR_PD_BIT]  = ccr_pd;
      SEL_SCK: rd_mux[SCK_W-1:0]   = sock_q;
      SEL_CSR: rd_mux              = status;
      SEL_WPR: rd_mux[WPR_W-1:0]   = wpr_q;
      SEL_SLP: rd_mux[NPAIR-1:0]   = sleep_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
  end

  assign soft_reset = cor_sr;
endmodule

// File: rtl/card_mgmt_regs_chk.sv
module card_mgmt_regs_chk
  import cmr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int NPAIR  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              wp_switch,
  input logic              soft_reset,
  input logic [NPAIR-1:0]  pair_pwrdn,
  input logic              cis_wr_ok,
  input logic              cm_wr_ok,
  input logic              attr_wr_ok,
  input logic              ccr_pd,
  input logic [SCK_W-1:0]  sock_q,
  input logic [WPR_W-1:0]  wpr_q,
  input logic [NPAIR-1:0]  sleep_q
);
  localparam logic [ADDR_W-1:0] A_COR = OFF_COR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_SCK = OFF_SCK[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CSR = OFF_CSR[ADDR_W-1:0];

  p_odd_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[0]) |=> ($stable(sock_q) && $stable(wpr_q) &&
                            $stable(sleep_q) && $stable(ccr_pd) && $stable(soft_reset)));

  p_soft_reset_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel && addr == A_COR) |=> (soft_reset == $past(wdata[COR_SR_BIT])));

  p_pair_pwrdn_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pair_pwrdn == ($past(ccr_pd) ? $past(sleep_q) : '0)));

  p_status_ro_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel && addr == A_CSR) |=> ($stable(sock_q) && $stable(wpr_q) &&
                                         $stable(sleep_q) && $stable(ccr_pd) && $stable(soft_reset)));

  p_attr_gate_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (attr_wr_ok == !$past(wp_switch)));

  p_cm_gate_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cm_wr_ok == (!$past(wp_switch) && !$past(wpr_q[WP_CM_BIT]))));

  p_cis_gate_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cis_wr_ok == (!$past(wp_switch) && !$past(wpr_q[WP_CIS_BIT]))));

  p_wr_under_switch_r10: assert property (@(posedge clk) disable iff (rst)
    (wp_switch && wr_en && sel && addr == A_SCK) |=> (sock_q == $past(wdata[SCK_W-1:0])));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind card_mgmt_regs card_mgmt_regs_chk #(.ADDR_W(ADDR_W), .NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .wp_switch(wp_switch), .soft_reset(soft_reset),
  .pair_pwrdn(pair_pwrdn), .cis_wr_ok(cis_wr_ok), .cm_wr_ok(cm_wr_ok),
  .attr_wr_ok(attr_wr_ok), .ccr_pd(ccr_pd), .sock_q(sock_q), .wpr_q(wpr_q),
  .sleep_q(sleep_q)
);

// File: tb/card_mgmt_regs_bench.sv
module card_mgmt_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 15;
  localparam int NPAIR  = 6;
  localparam int NDEV   = 2 * NPAIR;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = 8'h00;
  logic [7:0]        rdata;
  logic              wp_switch = 1'b0;
  logic [NDEV-1:0]   dev_ready = '0, dev_mask = '0;
  logic              soft_reset;
  logic [NPAIR-1:0]  pair_pwrdn;
  logic              cis_wr_ok, cm_wr_ok, attr_wr_ok;

  int checks = 0;
  int errors = 0;

  // model state
  logic             m_sr, m_pd;
  logic [6:0]       m_sck;
  logic [2:0]       m_wpr;
  logic [NPAIR-1:0] m_slp;
  logic [7:0]       m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_mgmt_regs #(.ADDR_W(ADDR_W), .NPAIR(NPAIR)) u_card_mgmt_regs (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wp_switch(wp_switch), .dev_ready(dev_ready),
    .dev_mask(dev_mask), .soft_reset(soft_reset), .pair_pwrdn(pair_pwrdn),
    .cis_wr_ok(cis_wr_ok), .cm_wr_ok(cm_wr_ok), .attr_wr_ok(attr_wr_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic s, input logic [ADDR_W-1:0] a,
      input logic sr, input logic pd, input logic [6:0] sck, input logic [2:0] wpr,
      input logic [NPAIR-1:0] slp, input logic sw, input logic [NDEV-1:0] rdy,
      input logic [NDEV-1:0] msk);
    logic [7:0] v;
    v = 8'h00;
    if (s && !a[0]) begin
      case ({1'b0, a})
        16'h4000: v = {sr, 7'b0};
        16'h4002: v = {5'b0, pd, 2'b0};
        16'h4006: v = {1'b0, sck};
        16'h4100: v = {|msk, |slp, sr, wpr[1], pd, wpr[0], sw, &(rdy | msk)};
        16'h4104: v = {5'b0, wpr};
        16'h4118: v = {{(8-NPAIR){1'b0}}, slp};
        default:  v = 8'h00;
      endcase
    end
    return v;
  endfunction

  function automatic string tag_of(input logic [ADDR_W-1:0] a);
    if (a[0]) return "R2";
    case ({1'b0, a})
      16'h4000: return "R3";
      16'h4002: return "R4";
      16'h4006: return "R5";
      16'h4100: return "R6";
      16'h4104: return "R8";
      16'h4118: return "R12";
      16'h411A: return "R12";
      default:  return "R2";
    endcase
  endfunction

  // one bus cycle: drive at negedge, check at the following negedge
  task automatic step(input logic s, input logic w, input logic r,
                      input logic [ADDR_W-1:0] a, input logic [7:0] d);
    logic p_pd, p_sw;
    logic [2:0] p_wpr;
    logic [NPAIR-1:0] p_slp;
    logic [7:0] e_rd;
    sel = s; wr_en = w; rd_en = r; addr = a; wdata = d;
    p_pd = m_pd; p_wpr = m_wpr; p_slp = m_slp; p_sw = wp_switch;
    e_rd = exp_rd(s, a, m_sr, m_pd, m_sck, m_wpr, m_slp, wp_switch, dev_ready, dev_mask);
    if (w && s && !a[0]) begin
      case ({1'b0, a})
        16'h4000: m_sr  = d[7];
        16'h4002: m_pd  = d[2];
        16'h4006: m_sck = d[6:0];
        16'h4104: m_wpr = d[2:0];
        16'h4118: m_slp = d[NPAIR-1:0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      m_rd = e_rd;
      chk(tag_of(a), {24'b0, rdata}, {24'b0, m_rd});
    end else begin
      chk("R11", {24'b0, rdata}, {24'b0, m_rd});
    end
    chk("R3", {31'b0, soft_reset}, {31'b0, m_sr});
    chk("R4", {26'b0, pair_pwrdn}, {26'b0, (p_pd ? p_slp : '0)});
    chk("R9", {29'b0, cis_wr_ok, cm_wr_ok, attr_wr_ok},
        {29'b0, !p_sw && !p_wpr[0], !p_sw && !p_wpr[1], !p_sw});
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] pick_addr();
    logic [ADDR_W-1:0] a;
    case ($urandom % 12)
      0: a = 15'h4000;  1: a = 15'h4002;  2: a = 15'h4006;
      3: a = 15'h4100;  4: a = 15'h4104;  5: a = 15'h4118;
      6: a = 15'h411A;  7: a = 15'h4000 | 15'(2 * ($urandom % 256));
      8: a = 15'h4001 | 15'(2 * ($urandom % 8));
      default: a = 15'h4100 | 15'(2 * ($urandom % 12));
    endcase
    return a;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_sr = 0; m_pd = 0; m_sck = '0; m_wpr = '0; m_slp = '0; m_rd = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {24'b0, rdata}, 32'h0);
    chk("R1", {26'b0, pair_pwrdn}, 32'h0);
    chk("R1", {29'b0, soft_reset, cm_wr_ok, attr_wr_ok}, 32'h0);
    chk("R1", {31'b0, cis_wr_ok}, 32'h0);
    rst = 1'b0;

    // directed: fill registers then read all back
    step(1, 1, 0, 15'h4000, 8'hFF);
    step(1, 1, 0, 15'h4002, 8'hFF);
    step(1, 1, 0, 15'h4006, 8'hFF);
    step(1, 1, 0, 15'h4104, 8'h07);
    step(1, 1, 0, 15'h4118, 8'hFF);
    step(1, 0, 1, 15'h4002, 8'h00);   // R4 readback bit 2 only
    step(1, 0, 1, 15'h4006, 8'h00);   // R5 bit 7 reads 0
    // R7: write to status, then stored registers unchanged
    step(1, 1, 0, 15'h4100, 8'h00);
    step(1, 0, 1, 15'h4104, 8'h00);
    step(1, 0, 1, 15'h4118, 8'h00);
    // R12: high sleep register inert
    step(1, 1, 0, 15'h411A, 8'hFF);
    step(1, 0, 1, 15'h411A, 8'h00);
    // R8: block-lock bit alone has no effect on gating
    step(1, 1, 0, 15'h4104, 8'h04);
    step(1, 0, 0, 15'h4000, 8'h00);
    step(1, 0, 1, 15'h4104, 8'h00);
    // R10: switch on, register writes still land
    wp_switch = 1'b1;
    step(1, 1, 0, 15'h4006, 8'h5A);
    step(1, 0, 1, 15'h4006, 8'h00);
    // R2: odd address and unselected writes ignored
    step(1, 1, 0, 15'h4007, 8'h11);
    step(0, 1, 0, 15'h4006, 8'h22);
    step(1, 0, 1, 15'h4006, 8'h00);
    // R6: status with all ready / one busy unmasked
    dev_ready = '1; dev_mask = '0;
    step(1, 0, 1, 15'h4100, 8'h00);
    dev_ready = 12'hFFE;
    step(1, 0, 1, 15'h4100, 8'h00);
    dev_mask = 12'h001;
    step(1, 0, 1, 15'h4100, 8'h00);
    // R11: read and write same cycle returns old value
    step(1, 1, 1, 15'h4006, 8'h33);
    step(1, 0, 1, 15'h4006, 8'h00);

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      wp_switch = 1'($urandom);
      dev_ready = NDEV'($urandom);
      dev_mask  = (($urandom % 4) == 0) ? NDEV'($urandom) : '0;
      if (($urandom % 8) == 0) dev_ready = '1;
      step(($urandom % 10) != 0, 1'($urandom), 1'($urandom),
           pick_addr(), 8'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule